// File: doc/BRIEF.md
# Inter-Processor Command Dispatcher

This block turns a software write into a command for one processor core. A write carries three fields: a two-bit command kind, a target core number and a six-bit vector. An accepted write produces a one-cycle strobe on the per-core output that belongs to the chosen action. The four actions are posting an interrupt, resetting the core, halting it, and waking it.

A per-core halted flag follows the idle and wake commands. A reset is only legal with the power-on-reset vector. Any other vector raises a sticky error flag and issues nothing. A write that names a core beyond the configured count is dropped with no effect at all. The block does not carry out resets or halts itself; the cores act on the strobes.

Top module: `ipi_dispatch`

## Requirements
- R1: A write with kind 0 (bits 17:16 = 0) to an existing core (id in bits 12:8) raises `irq_stb` for that core only. The cycle after the write, `irq_vec` holds the write's bits 5:0.
- R2: A write whose core id is equal to or greater than `NCORES` raises no strobe. It leaves `halted` and `err_flag` unchanged, even when it is a reset with a wrong vector.
- R3: A write with kind 1 and vector equal to `POR_VEC` (default 1) raises both `rst_stb` and `wake_stb` for the target core and clears its halted bit.
- R4: A write with kind 1 and any other vector raises no strobe and sets `err_flag`. Once set, `err_flag` stays set until reset.
- R5: A write with kind 2 raises `halt_stb` for the target core and sets its `halted` bit.
- R6: A write with kind 3 raises `wake_stb` for the target core and clears its `halted` bit.
- R7: Each accepted write produces strobes for exactly one cycle. At most one core and one action strobe at a time, except that a reset strobes both `rst_stb` and `wake_stb`. A cycle with `cmd_valid` low produces no strobe.
- R8: After reset, all strobes, `irq_vec`, `halted` and `err_flag` are zero.
- R9: An interrupt sent to a halted core is still posted and leaves the core halted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Write strobe for the dispatch register |
| cmd_data | input | 18 | Write data: kind 17:16, core id 12:8, vector 5:0 |
| irq_stb | output | NCORES | Per-core interrupt post strobe |
| irq_vec | output | 6 | Vector of the last posted interrupt |
| rst_stb | output | NCORES | Per-core reset strobe |
| halt_stb | output | NCORES | Per-core halt strobe |
| wake_stb | output | NCORES | Per-core activate strobe (wake or reset) |
| halted | output | NCORES | Per-core halted status |
| err_flag | output | 1 | Sticky bad-reset-vector error |

## Verification
The assertions check four things on every cycle:
- No two actions strobe together, apart from the reset-with-wake pair.
- A halt strobe always comes with the halted bit set, and a wake strobe with it clear.
- An out-of-range write has no effect on the next cycle.
- The error flag never falls outside reset.

Only the bench scenarios can show that the right core and the right vector are chosen from the field layout. The same holds for the difference between a good and a bad reset vector, and for an interrupt to a halted core leaving it halted.

// File: rtl/ipi_dispatch.sv
module ipi_dispatch #(
  parameter int NCORES  = 8,
  parameter int POR_VEC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [17:0]       cmd_data,
  output logic [NCORES-1:0] irq_stb,
  output logic [5:0]        irq_vec,
  output logic [NCORES-1:0] rst_stb,
  output logic [NCORES-1:0] halt_stb,
  output logic [NCORES-1:0] wake_stb,
  output logic [NCORES-1:0] halted,
  output logic              err_flag
);
  localparam int VEC_W = 6;
  localparam int ID_W  = 5;

  wire [1:0]       kind = cmd_data[17:16];
  wire [ID_W-1:0]  id   = cmd_data[12:8];
  wire [VEC_W-1:0] vec  = cmd_data[5:0];

  wire in_range = 32'(id) < NCORES;
  wire accept   = cmd_valid && in_range;
  wire vec_ok   = vec == VEC_W'(POR_VEC);

  wire [NCORES-1:0] sel = accept ? ({{(NCORES-1){1'b0}}, 1'b1} << id) : '0;

  wire [NCORES-1:0] sel_irq  = (kind == 2'd0) ? sel : '0;
  wire [NCORES-1:0] sel_rst  = (kind == 2'd1 && vec_ok) ? sel : '0;
  wire [NCORES-1:0] sel_halt = (kind == 2'd2) ? sel : '0;
  wire [NCORES-1:0] sel_wake = (kind == 2'd3) ? sel : sel_rst;
  wire              bad_rst  = accept && kind == 2'd1 && !vec_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_stb  <= '0;
      irq_vec  <= '0;
      rst_stb  <= '0;
      halt_stb <= '0;
      wake_stb <= '0;
      halted   <= '0;
      err_flag <= 1'b0;
    end else begin
      irq_stb  <= sel_irq;
      rst_stb  <= sel_rst;
      halt_stb <= sel_halt;
      wake_stb <= sel_wake;
      halted   <= (halted | sel_halt) & ~sel_wake;
      err_flag <= err_flag | bad_rst;
      if (|sel_irq) irq_vec <= vec;
    end
  end
endmodule

module ipi_dispatch_chk #(
  parameter int NCORES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [17:0]       cmd_data,
  input logic [NCORES-1:0] irq_stb,
  input logic [NCORES-1:0] rst_stb,
  input logic [NCORES-1:0] halt_stb,
  input logic [NCORES-1:0] wake_stb,
  input logic [NCORES-1:0] halted,
  input logic              err_flag
);
  wire idle_in = !cmd_valid;
  wire far_id  = cmd_valid && (32'(cmd_data[12:8]) >= NCORES);

  // R7
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({irq_stb, rst_stb, halt_stb, (wake_stb & ~rst_stb)}) <= 1);

  // R7
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_in |=> (irq_stb == '0 && rst_stb == '0 && halt_stb == '0 && wake_stb == '0));

  // R5
  halt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_stb & ~halted) == '0);

  // R6
  wake_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_stb & halted) == '0);

  // R3
  rst_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_stb & ~wake_stb) == '0);

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R2
  far_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    far_id |=> (irq_stb == '0 && rst_stb == '0 && halt_stb == '0 && wake_stb == '0
                && $stable(halted) && $stable(err_flag)));
endmodule

bind ipi_dispatch ipi_dispatch_chk #(.NCORES(NCORES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
  .irq_stb(irq_stb), .rst_stb(rst_stb), .halt_stb(halt_stb),
  .wake_stb(wake_stb), .halted(halted), .err_flag(err_flag)
);

// File: tb/sim_ipi_dispatch.sv
`timescale 1ns/1ps
module sim_ipi_dispatch;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [17:0] cmd_data = '0;
  logic [N-1:0] irq_stb, rst_stb, halt_stb, wake_stb, halted;
  logic [5:0] irq_vec;
  logic err_flag;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ipi_dispatch #(.NCORES(N), .POR_VEC(1)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .irq_stb(irq_stb), .irq_vec(irq_vec), .rst_stb(rst_stb),
    .halt_stb(halt_stb), .wake_stb(wake_stb), .halted(halted), .err_flag(err_flag)
  );

  typedef struct {
    logic [N-1:0] irq, rst, hlt, wak, hst;
    logic [5:0]   vec;
    logic         err;
    string        tag;
  } exp_t;

  exp_t q[$];
  logic [N-1:0] m_halted = '0;
  logic m_err = 1'b0;

  task automatic send(input bit v, input int kind, input int id, input int vec, input string tag);
    exp_t e;
    logic [N-1:0] s;
    @(negedge clk);
    cmd_valid = v;
    cmd_data  = {2'(kind), 3'b0, 5'(id), 2'b0, 6'(vec)};
    s = (v && id < N) ? (N'(1) << id) : '0;
    e.irq = (kind == 0) ? s : '0;
    e.rst = (kind == 1 && vec == 1) ? s : '0;
    e.hlt = (kind == 2) ? s : '0;
    e.wak = (kind == 3) ? s : e.rst;
    if (kind == 1 && vec != 1 && s != '0) m_err = 1'b1;
    m_halted = (m_halted | e.hlt) & ~e.wak;
    e.hst = m_halted;
    e.err = m_err;
    e.vec = 6'(vec);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic gap(input string tag);
    send(1'b0, 0, 0, 0, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_tests++;
        if (irq_stb !== e.irq || rst_stb !== e.rst || halt_stb !== e.hlt ||
            wake_stb !== e.wak || halted !== e.hst || err_flag !== e.err ||
            (e.irq != '0 && irq_vec !== e.vec)) begin
          n_fail++;
          $display("FAIL %s: irq=%b rst=%b halt=%b wake=%b halted=%b err=%b vec=%0d, expected irq=%b rst=%b halt=%b wake=%b halted=%b err=%b vec=%0d",
                   e.tag, irq_stb, rst_stb, halt_stb, wake_stb, halted, err_flag, irq_vec,
                   e.irq, e.rst, e.hlt, e.wak, e.hst, e.err, e.vec);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_tests++;
    if ({irq_stb, rst_stb, halt_stb, wake_stb, halted, irq_vec, err_flag} !== '0) begin
      n_fail++;
      $display("FAIL R8: outputs=%h expected 0",
               {irq_stb, rst_stb, halt_stb, wake_stb, halted, irq_vec, err_flag});
    end
    @(negedge clk);
    rst_n = 1'b1;

    send(1, 0, 3, 42, "R1 irq core3");
    gap("R7 strobe drops");
    send(1, 0, 0, 5, "R1 irq core0");
    send(1, 0, 7, 63, "R1 irq core7 back-to-back");
    send(0, 2, 4, 0, "R7 no valid no effect");
    send(1, 2, 8, 0, "R2 halt id 8 ignored");
    send(1, 1, 31, 9, "R2 bad reset id 31 ignored");
    send(1, 2, 2, 0, "R5 halt core2");
    gap("R5 halted holds");
    send(1, 0, 2, 17, "R9 irq to halted core2");
    send(1, 3, 2, 0, "R6 wake core2");
    send(1, 2, 5, 0, "R5 halt core5");
    send(1, 2, 6, 0, "R5 halt core6");
    send(1, 1, 5, 1, "R3 reset core5 good vector");
    gap("R7 after reset");
    send(1, 1, 6, 2, "R4 reset core6 bad vector");
    send(1, 0, 1, 12, "R4 err sticky");
    send(1, 3, 6, 0, "R6 wake core6");
    gap("R4 err still set");
    gap("final");

    repeat (4) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule